// File: doc/BRIEF.md
# Indirect Command/Status Register Port

This block is the host-facing register file of a network controller. The host sees only two locations. One is a 2-bit register selector and the other is a 16-bit data window. The value held in the selector decides which of four internal registers the data window reaches. The selector keeps its value between accesses. Software that leaves it at 0 therefore reaches the command/status register with a single access.

Register 0 combines three kinds of bit:
- Event flags that the rest of the controller raises with single-cycle pulses. Software clears each one by writing a 1 to it.
- Two read-only summary bits.
- Command bits. Writing a 1 sets these bits, and each written 1 also leaves the block as a one-cycle strobe.

The interrupt output combines the summary with an enable bit. Registers 1 to 3 hold the 24-bit setup-block address and three mode bits. They accept writes only while the controller is stopped.

Top module: `nic_csr_port`

## Requirements
- R1: A write with `host_port_sel`=1 loads `host_wdata[1:0]` into the selector. The selector holds its value until the next such write. A read with `host_port_sel`=1 returns the selector in bits 1:0 and zeros above. A read or write with `host_port_sel`=0 reaches the register the selector names (0 to 3). Writes take effect at the clock edge and are visible on the next read.
- R2: After reset the selector is 0, register 0 reads 16'h0004 (stop set), registers 1 to 3 read 0, and `irq` is 0.
- R3: Register 0 bits 14..8 are, in order: babble, heartbeat error, missed packet, memory error, receive done, transmit done and init done. They are driven by `ev_flags[6:0]` (bit 6 = babble, bit 0 = init done). A pulse sets the flag, and the flag reads 1 from the next cycle. Writing 1 clears a flag and writing 0 leaves it. A pulse in the same cycle as a clearing write leaves the flag set.
- R4: Bit 15 is read-only and equals the OR of bits 14, 13, 12 and 11.
- R5: Bit 7 is read-only and equals the OR of bits 14, 12, 11, 10, 9 and 8. The heartbeat error (bit 13) does not contribute.
- R6: Bit 6 (interrupt enable) is loaded from the written data on every register 0 write.
- R7: Bits 5 (receiver on) and 4 (transmitter on) are read-only. They are set by `ev_rx_on` and `ev_tx_on` while stop is 0, and a register 0 write cannot set them.
- R8: Bit 3 always reads 0. Writing 1 to it makes `cmd_tx_demand` high for exactly the cycle after the write.
- R9: Bits 2 (stop), 1 (start) and 0 (init) read back, and a written 1 sets them. Writing 1 to start or init clears stop. Writing 1 to stop clears start, init, receiver on and transmitter on, and this takes priority over the other two. Each written 1 among bits 2..0 makes `cmd_stop`, `cmd_start` or `cmd_init` high for the cycle after the write.
- R10: Register 1 holds setup address bits 15:0. Register 2 holds bits 23:16 in its low byte, and its upper byte always reads 0. `setup_addr` presents the 24-bit value.
- R11: Register 3 holds byte swap in bit 2, address-latch polarity in bit 1 and byte control in bit 0. Its bits 15:3 read 0, and `mode_bits` presents bits 2:0.
- R12: A write to register 1, 2 or 3 while stop is 0 leaves that register unchanged.
- R13: `irq` is 1 exactly when bit 7 and bit 6 of register 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_port_sel | input | 1 | 1 = selector location, 0 = data window |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the addressed location |
| ev_flags | input | 7 | Event pulses: babble, heartbeat, missed, memory, rx done, tx done, init done |
| ev_rx_on | input | 1 | Pulse: receiver became active |
| ev_tx_on | input | 1 | Pulse: transmitter became active |
| cmd_init | output | 1 | Init command strobe |
| cmd_start | output | 1 | Start command strobe |
| cmd_stop | output | 1 | Stop command strobe |
| cmd_tx_demand | output | 1 | Transmit demand strobe |
| irq | output | 1 | Interrupt request |
| setup_addr | output | 24 | Setup-block address |
| mode_bits | output | 3 | Mode bits: swap, latch polarity, byte control |

## Verification
The bench drives an event pulse in the same cycle as a write that clears the same flag. A design that let the clear win would lose that event. It raises only the heartbeat error and checks that bit 7 and `irq` stay low. A design that folded this flag into the interrupt summary would interrupt on a non-interrupting condition. It writes the setup registers while running and while stopped, so a missing write lock shows up as a changed address. Random mixes of selector moves, writes with arbitrary bit masks and event bursts check how stop, start and init interact. They also check that transmit demand reads back as 0 and that every command strobe lasts one cycle.

// File: rtl/nic_csr_pkg.sv
`timescale 1ns/1ps
package nic_csr_pkg;
    localparam int DATA_W = 16;
    localparam int FLAG_W = 7;
    localparam int CMD_W  = 4;
    // flag vector order: [6] babble [5] heartbeat [4] missed [3] memory [2] rx [1] tx [0] init done
    localparam logic [FLAG_W-1:0] ERR_MASK  = 7'b1111000;
    localparam logic [FLAG_W-1:0] INTR_MASK = 7'b1011111;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic              inea;
        logic              rxon;
        logic              txon;
        logic              stop;
        logic              strt;
        logic              init;
        logic [CMD_W-1:0]  pulse;   // [3] tx demand [2] stop [1] start [0] init
    } csr0_state_t;

    localparam csr0_state_t CSR0_RESET = '{flags: '0, inea: 1'b0, rxon: 1'b0, txon: 1'b0,
                                           stop: 1'b1, strt: 1'b0, init: 1'b0, pulse: '0};
endpackage

// File: rtl/nic_csr_host_port.sv
`timescale 1ns/1ps
module nic_csr_host_port #(
    parameter int REG_W  = 2,
    parameter int DATA_W = 16,
    localparam int NUM_REGS = 1 << REG_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             port_sel_i,
    input  logic                             wr_i,
    input  logic [REG_W-1:0]                 sel_wdata_i,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  reg_rd_i,
    output logic [NUM_REGS-1:0]              wr_sel_o,
    output logic [DATA_W-1:0]                rdata_o
);
    logic [REG_W-1:0] rap_d, rap_q;

    always_comb begin
        rap_d = rap_q;
        if (wr_i && port_sel_i) rap_d = sel_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rap_q <= '0;
        else        rap_q <= rap_d;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_wsel
        assign wr_sel_o[g] = wr_i && !port_sel_i && (rap_q == REG_W'(g));
    end

    assign rdata_o = port_sel_i ? {{(DATA_W-REG_W){1'b0}}, rap_q} : reg_rd_i[rap_q];

    // R1: the selector only moves on a write to its own location
    assert_sel_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && port_sel_i) |=> $stable(rap_q));
    // R1: at most one register receives a data write
    assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && port_sel_i) |-> (wr_sel_o == '0));
endmodule

// File: rtl/nic_csr_status.sv
`timescale 1ns/1ps
module nic_csr_status
    import nic_csr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [FLAG_W-1:0]    wr_clr_i,
    input  logic                 wr_inea_i,
    input  logic [CMD_W-1:0]     wr_cmd_i,
    input  logic [FLAG_W-1:0]    evt_i,
    input  logic                 evt_rx_on_i,
    input  logic                 evt_tx_on_i,
    output logic [DATA_W-1:0]    rd_o,
    output logic [CMD_W-1:0]     pulse_o,
    output logic                 stop_o,
    output logic                 irq_o
);
    csr0_state_t s_d, s_q;
    logic err_sum, intr_sum;

    always_comb begin
        s_d       = s_q;
        s_d.flags = (s_q.flags & ~(wr_i ? wr_clr_i : '0)) | evt_i;
        s_d.pulse = wr_i ? wr_cmd_i : '0;
        if (wr_i) s_d.inea = wr_inea_i;
        if (evt_rx_on_i && !s_q.stop) s_d.rxon = 1'b1;
        if (evt_tx_on_i && !s_q.stop) s_d.txon = 1'b1;
        if (wr_i && (wr_cmd_i[1] || wr_cmd_i[0])) s_d.stop = 1'b0;
        if (wr_i && wr_cmd_i[1]) s_d.strt = 1'b1;
        if (wr_i && wr_cmd_i[0]) s_d.init = 1'b1;
        if (wr_i && wr_cmd_i[2]) begin
            s_d.stop = 1'b1;
            s_d.strt = 1'b0;
            s_d.init = 1'b0;
            s_d.rxon = 1'b0;
            s_d.txon = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CSR0_RESET;
        else        s_q <= s_d;
    end

    assign err_sum  = |(s_q.flags & ERR_MASK);
    assign intr_sum = |(s_q.flags & INTR_MASK);
    assign rd_o     = {err_sum, s_q.flags, intr_sum, s_q.inea, s_q.rxon, s_q.txon,
                       1'b0, s_q.stop, s_q.strt, s_q.init};
    assign pulse_o  = s_q.pulse;
    assign stop_o   = s_q.stop;
    assign irq_o    = intr_sum & s_q.inea;

    // R3: an event pulse always lands, even against a clearing write
    assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((s_q.flags & $past(evt_i)) == $past(evt_i)));
    // R9 (and R7): a stop command clears the running state
    assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wr_cmd_i[2]) |=> (s_q.stop && !s_q.strt && !s_q.init && !s_q.rxon && !s_q.txon));
    // R8: the tx demand strobe only follows a written 1
    assert_tdmd_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o[3]) |-> $past(wr_i && wr_cmd_i[3]));
    // R13: an interrupting event with the enable held raises irq
    assert_irq_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(evt_i & INTR_MASK)) && s_q.inea && !wr_i) |=> irq_o);
endmodule

// File: rtl/nic_csr_setup.sv
`timescale 1ns/1ps
module nic_csr_setup #(
    parameter int LO_W   = 16,
    parameter int HI_W   = 8,
    parameter int MODE_W = 3,
    localparam int ADDR_W = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlock_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic              wr_mode_i,
    input  logic [LO_W-1:0]   wdata_lo_i,
    input  logic [HI_W-1:0]   wdata_hi_i,
    input  logic [MODE_W-1:0] wdata_mode_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [MODE_W-1:0] mode_o
);
    typedef struct packed {
        logic [LO_W-1:0]   lo;
        logic [HI_W-1:0]   hi;
        logic [MODE_W-1:0] mode;
    } setup_t;

    setup_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (unlock_i && wr_lo_i)   r_d.lo   = wdata_lo_i;
        if (unlock_i && wr_hi_i)   r_d.hi   = wdata_hi_i;
        if (unlock_i && wr_mode_i) r_d.mode = wdata_mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr_o = {r_q.hi, r_q.lo};
    assign mode_o = r_q.mode;

    // R12: setup registers are frozen while the controller runs
    assert_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock_i |=> ($stable(addr_o) && $stable(mode_o)));
endmodule

// File: rtl/nic_csr_port.sv
`timescale 1ns/1ps
module nic_csr_port
    import nic_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_port_sel,
    input  logic        host_wr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic [6:0]  ev_flags,
    input  logic        ev_rx_on,
    input  logic        ev_tx_on,
    output logic        cmd_init,
    output logic        cmd_start,
    output logic        cmd_stop,
    output logic        cmd_tx_demand,
    output logic        irq,
    output logic [23:0] setup_addr,
    output logic [2:0]  mode_bits
);
    localparam int REG_W    = 2;
    localparam int NUM_REGS = 1 << REG_W;
    localparam int LO_W     = 16;
    localparam int HI_W     = 8;
    localparam int MODE_W   = 3;

    logic [NUM_REGS-1:0]             wr_sel;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_rd;
    logic [CMD_W-1:0]                pulses;
    logic                            stopped;

    nic_csr_host_port #(.REG_W(REG_W), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .port_sel_i(host_port_sel), .wr_i(host_wr),
        .sel_wdata_i(host_wdata[REG_W-1:0]),
        .reg_rd_i(regs_rd), .wr_sel_o(wr_sel), .rdata_o(host_rdata)
    );

    nic_csr_status u_csr0 (
        .clk(clk), .rst_n(rst_n),
        .wr_i(wr_sel[0]),
        .wr_clr_i(host_wdata[14:8]),
        .wr_inea_i(host_wdata[6]),
        .wr_cmd_i(host_wdata[3:0]),
        .evt_i(ev_flags), .evt_rx_on_i(ev_rx_on), .evt_tx_on_i(ev_tx_on),
        .rd_o(regs_rd[0]), .pulse_o(pulses), .stop_o(stopped), .irq_o(irq)
    );

    nic_csr_setup #(.LO_W(LO_W), .HI_W(HI_W), .MODE_W(MODE_W)) u_setup (
        .clk(clk), .rst_n(rst_n),
        .unlock_i(stopped),
        .wr_lo_i(wr_sel[1]), .wr_hi_i(wr_sel[2]), .wr_mode_i(wr_sel[3]),
        .wdata_lo_i(host_wdata[LO_W-1:0]),
        .wdata_hi_i(host_wdata[HI_W-1:0]),
        .wdata_mode_i(host_wdata[MODE_W-1:0]),
        .addr_o(setup_addr), .mode_o(mode_bits)
    );

    assign regs_rd[1] = setup_addr[LO_W-1:0];
    assign regs_rd[2] = {{(DATA_W-HI_W){1'b0}}, setup_addr[LO_W+HI_W-1:LO_W]};
    assign regs_rd[3] = {{(DATA_W-MODE_W){1'b0}}, mode_bits};

    assign cmd_init      = pulses[0];
    assign cmd_start     = pulses[1];
    assign cmd_stop      = pulses[2];
    assign cmd_tx_demand = pulses[3];
endmodule

// File: tb/nic_csr_port_test.sv
`timescale 1ns/1ps
module nic_csr_port_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, host_port_sel, host_wr, ev_rx_on, ev_tx_on;
    logic [15:0] host_wdata, host_rdata;
    logic [6:0]  ev_flags;
    logic        cmd_init, cmd_start, cmd_stop, cmd_tx_demand, irq;
    logic [23:0] setup_addr;
    logic [2:0]  mode_bits;

    nic_csr_port uut (.*);

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model built from the requirements
    logic [1:0]  m_rap;
    logic [6:0]  m_flags;
    logic        m_inea, m_rxon, m_txon, m_stop, m_strt, m_init;
    logic [15:0] m_lo;
    logic [7:0]  m_hi;
    logic [2:0]  m_mode;
    logic [3:0]  m_pulse;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic err_of(logic [6:0] f);   // R4: bits 14..11
        return f[6] | f[5] | f[4] | f[3];
    endfunction

    function automatic logic intr_of(logic [6:0] f);  // R5: heartbeat excluded
        return f[6] | f[4] | f[3] | f[2] | f[1] | f[0];
    endfunction

    function automatic logic [15:0] exp_reg(logic [1:0] k);
        case (k)
            2'd0: return {err_of(m_flags), m_flags, intr_of(m_flags), m_inea, m_rxon, m_txon,
                          1'b0, m_stop, m_strt, m_init};
            2'd1: return m_lo;
            2'd2: return {8'h00, m_hi};
            default: return {13'h0, m_mode};
        endcase
    endfunction

    task automatic model_update(logic psel, logic wr, logic [15:0] wd,
                                logic [6:0] ev, logic erx, logic etx);
        logic w0;
        logic old_stop;
        w0 = wr && !psel && (m_rap == 2'd0);
        old_stop = m_stop;
        m_flags = (m_flags & ~(w0 ? wd[14:8] : 7'h0)) | ev;
        m_pulse = w0 ? wd[3:0] : 4'h0;
        if (w0) m_inea = wd[6];
        if (erx && !old_stop) m_rxon = 1'b1;
        if (etx && !old_stop) m_txon = 1'b1;
        if (w0 && (wd[1] || wd[0])) m_stop = 1'b0;
        if (w0 && wd[1]) m_strt = 1'b1;
        if (w0 && wd[0]) m_init = 1'b1;
        if (w0 && wd[2]) begin
            m_stop = 1'b1; m_strt = 1'b0; m_init = 1'b0; m_rxon = 1'b0; m_txon = 1'b0;
        end
        if (wr && !psel && old_stop) begin
            if (m_rap == 2'd1) m_lo   = wd;
            if (m_rap == 2'd2) m_hi   = wd[7:0];
            if (m_rap == 2'd3) m_mode = wd[2:0];
        end
        if (wr && psel) m_rap = wd[1:0];
    endtask

    // drive at the falling edge, let one rising edge pass, check at the next falling edge
    task automatic step(logic psel, logic wr, logic [15:0] wd,
                        logic [6:0] ev, logic erx, logic etx);
        host_port_sel = psel; host_wr = wr; host_wdata = wd;
        ev_flags = ev; ev_rx_on = erx; ev_tx_on = etx;
        @(posedge clk);
        model_update(psel, wr, wd, ev, erx, etx);
        @(negedge clk);
        host_wr = 1'b0; ev_flags = '0; ev_rx_on = 1'b0; ev_tx_on = 1'b0;
        host_port_sel = 1'b1;
        #0.3;
        chk("R1 selector readback", host_rdata, {14'h0, m_rap});
        host_port_sel = 1'b0;
        #0.3;
        if (m_rap == 2'd0)
            chk("R3 R4 R5 R6 R7 R8 R9 register 0", host_rdata, exp_reg(2'd0));
        else if (m_rap == 2'd3)
            chk("R11 R12 register 3", host_rdata, exp_reg(2'd3));
        else
            chk("R10 R12 address registers", host_rdata, exp_reg(m_rap));
        chk("R13 irq", irq, intr_of(m_flags) & m_inea);
        chk("R8 R9 command strobes", {cmd_tx_demand, cmd_stop, cmd_start, cmd_init}, m_pulse);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; host_port_sel = 1'b0; host_wr = 1'b0; host_wdata = '0;
        ev_flags = '0; ev_rx_on = 1'b0; ev_tx_on = 1'b0;
        m_rap = 2'd0; m_flags = '0; m_inea = 1'b0; m_rxon = 1'b0; m_txon = 1'b0;
        m_stop = 1'b1; m_strt = 1'b0; m_init = 1'b0; m_lo = '0; m_hi = '0; m_mode = '0;
        m_pulse = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.3;
        chk("R2 register 0 reset", host_rdata, 16'h0004);
        chk("R2 irq reset", irq, 1'b0);
        host_port_sel = 1'b1;
        #0.3;
        chk("R2 selector reset", host_rdata, 16'h0000);
        host_port_sel = 1'b0;
        for (int k = 1; k < 4; k++) begin
            step(1'b1, 1'b1, 16'(k), 7'h0, 1'b0, 1'b0);
            chk("R2 setup register reset", host_rdata, 16'h0000);
        end

        // R3: event pulse against a clearing write
        step(1'b1, 1'b1, 16'h0000, 7'h0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 16'h0000, 7'b1000000, 1'b0, 1'b0);
        chk("R3 babble set", host_rdata[14], 1'b1);
        chk("R4 error summary", host_rdata[15], 1'b1);
        step(1'b0, 1'b1, 16'h4000, 7'b1000000, 1'b0, 1'b0);
        chk("R3 event beats clear", host_rdata[14], 1'b1);
        step(1'b0, 1'b1, 16'h4000, 7'h0, 1'b0, 1'b0);
        chk("R3 write 1 clears", host_rdata[14], 1'b0);
        // R5 R13: heartbeat alone must not interrupt
        step(1'b0, 1'b1, 16'h0040, 7'b0100000, 1'b0, 1'b0);
        chk("R5 heartbeat excluded from summary", host_rdata[7], 1'b0);
        chk("R4 heartbeat in error summary", host_rdata[15], 1'b1);
        chk("R13 no irq on heartbeat", irq, 1'b0);
        step(1'b0, 1'b0, 16'h0000, 7'b0000100, 1'b0, 1'b0);
        chk("R13 irq on rx done", irq, 1'b1);
        step(1'b0, 1'b1, 16'h7f48, 7'h0, 1'b0, 1'b0);
        chk("R8 tx demand strobe", cmd_tx_demand, 1'b1);
        chk("R8 tx demand reads 0", host_rdata[3], 1'b0);
        chk("R6 enable loaded from write", host_rdata[6], 1'b1);
        // R12: locked while running, open while stopped
        step(1'b0, 1'b1, 16'h0002, 7'h0, 1'b0, 1'b0);
        chk("R9 start clears stop", host_rdata[2:0], 3'b010);
        step(1'b0, 1'b0, 16'h0000, 7'h0, 1'b1, 1'b1);
        chk("R7 rx and tx on", host_rdata[5:4], 2'b11);
        step(1'b1, 1'b1, 16'h0001, 7'h0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 16'hbeef, 7'h0, 1'b0, 1'b0);
        chk("R12 write ignored while running", host_rdata, 16'h0000);
        step(1'b1, 1'b1, 16'h0000, 7'h0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 16'h0004, 7'h0, 1'b0, 1'b0);
        chk("R9 R7 stop clears run state", host_rdata[5:0], 6'b000100);
        step(1'b1, 1'b1, 16'h0001, 7'h0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 16'hbeef, 7'h0, 1'b0, 1'b0);
        chk("R10 low address", host_rdata, 16'hbeef);
        step(1'b1, 1'b1, 16'h0002, 7'h0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 16'hffa5, 7'h0, 1'b0, 1'b0);
        chk("R10 high byte only", host_rdata, 16'h00a5);
        chk("R10 setup address output", setup_addr, 24'ha5beef);
        step(1'b1, 1'b1, 16'h0003, 7'h0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 16'hffff, 7'h0, 1'b0, 1'b0);
        chk("R11 mode register", host_rdata, 16'h0007);
        chk("R11 mode output", mode_bits, 3'b111);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [15:0] wd;
            logic [6:0]  ev;
            r  = int'($urandom % 10);
            wd = 16'($urandom);
            if (($urandom % 4) != 0) wd[2] = 1'b0;
            ev = 7'($urandom & $urandom & $urandom);
            if (r < 2)
                step(1'b1, 1'b1, wd, ev, ($urandom % 8) == 0, ($urandom % 8) == 0);
            else if (r < 7)
                step(1'b0, 1'b1, wd, ev, ($urandom % 8) == 0, ($urandom % 8) == 0);
            else
                step(1'b0, 1'b0, wd, ev, ($urandom % 4) == 0, ($urandom % 4) == 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule